// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes a three-wire serial audio stream (a bit clock, a frame clock that marks left and right halves, and a data line) and turns it into parallel stereo samples. All three lines are sampled by a much faster system clock. They pass through synchronizers, and the block detects the rising edges of the bit clock in the system clock domain. Data bits are two's complement, MSB first, and each one is taken on a bit-clock rising edge.

A two-bit format selector picks one of four framings:
- 16-bit right-justified.
- 18-bit right-justified.
- 18-bit left-justified.
- I2S-style, where the frame clock is low for the left channel and the MSB lags the frame-clock change by one bit clock.

Each completed left/right pair is presented as two 18-bit words with a one-cycle strobe. Shorter words are left-aligned and padded with zeros.

Top module: `aud_serial_rx`

## Requirements
- R1: While `rst_n` is low, `pair_stb_o` is 0 and `left_o` and `right_o` are all zeros.
- R2: With `fmt_sel_i` = 2'b00, a word is the last 16 bits before a frame-clock change, at 32 or more bit clocks per frame. It is output as {word, 2'b00}, so bits [1:0] are zero, and earlier bits in the half are ignored.
- R3: With `fmt_sel_i` = 2'b01, a word is the last 18 bits before a frame-clock change, at 36 or more bit clocks per frame, and earlier bits in the half are ignored.
- R4: With `fmt_sel_i` = 2'b10, a word is the first 18 bits starting at the frame-clock change, at 36 or more bit clocks per frame. Later bits in the half are ignored. A 16-bit source padded with two zero LSBs comes out unchanged.
- R5: With `fmt_sel_i` = 2'b11, the MSB is the bit at the second bit-clock rise after the frame-clock change, and at most 18 bits are kept. At 32 bit clocks per frame, each 16-bit word is output as {word, 2'b00}.
- R6: In formats 00, 01 and 10, frame clock high carries the left word. In format 11, frame clock low carries the left word. `left_o` and `right_o` carry the two words of the same frame.
- R7: `pair_stb_o` pulses for one system-clock cycle after each right word completes, which is at the first bit-clock rise after the frame clock returns to the left level. `left_o` and `right_o` change only in a strobe cycle.
- R8: After reset, the first frame-clock change only starts framing, and no word is produced for it. A pair is produced only when a left word is followed by a right word. A right word with no left word before it is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| frame_clk_i | input | 1 | Frame (left/right) clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, MSB first |
| fmt_sel_i | input | 2 | Framing select: 00 RJ16, 01 RJ18, 10 LJ18, 11 I2S |
| pair_stb_o | output | 1 | One-cycle strobe when a new pair is valid |
| left_o | output | 18 | Left sample, left-aligned |
| right_o | output | 18 | Right sample, left-aligned |

## Verification
A wrong shift or count state shows up as a rotated or truncated word at the next strobe. That is at most one frame after the fault, because the words are rebuilt from scratch in every half. A wrong channel or priming state shows up as swapped words, a missing strobe or an extra strobe. The bench models each framing with bit-level queues and compares every strobe against them. It deliberately fills the unused bits of each half with ones, so that a wrong window choice corrupts the words.

// File: rtl/aud_rx_pkg.sv
package aud_rx_pkg;
  typedef enum logic [1:0] {
    FMT_RJ16 = 2'b00,
    FMT_RJ18 = 2'b01,
    FMT_LJ18 = 2'b10,
    FMT_I2S  = 2'b11
  } frame_fmt_e;
endpackage

// File: rtl/aud_rx_sync.sv
module aud_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= din;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/aud_rx_word.sv
module aud_rx_word
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W = 18,
  parameter int SHORT_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_rise,
  input  logic                ws_s,
  input  logic                sd_s,
  input  frame_fmt_e          fmt,
  output logic                word_valid,
  output logic                word_left,
  output logic [SAMPLE_W-1:0] word_data
);
  localparam int CNT_W = $clog2(SAMPLE_W + 1);
  localparam int PAD_W = SAMPLE_W - SHORT_W;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SAMPLE_W);

  function automatic logic [SAMPLE_W-1:0] left_align(input logic [SAMPLE_W-1:0] v,
                                                     input logic [CNT_W-1:0] n);
    return v << (FULL - n);
  endfunction

  logic [SAMPLE_W-1:0] shreg_q, shreg_d, shifted, cap_val, data_q, data_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic ws_prev_q, ws_prev_d, seen_q, seen_d, primed_q, primed_d;
  logic valid_q, valid_d, left_q, left_d;
  logic trans, not_full, capture;

  always_comb begin
    shifted   = {shreg_q[SAMPLE_W-2:0], sd_s};
    trans     = seen_q && (ws_s != ws_prev_q);
    not_full  = cnt_q < FULL;
    shreg_d   = shreg_q;
    cnt_d     = cnt_q;
    ws_prev_d = ws_prev_q;
    seen_d    = seen_q;
    primed_d  = primed_q;
    valid_d   = 1'b0;
    left_d    = left_q;
    data_d    = data_q;
    capture   = 1'b0;
    cap_val   = '0;
    if (bit_rise) begin
      seen_d    = 1'b1;
      ws_prev_d = ws_s;
      if (trans) primed_d = 1'b1;
      unique case (fmt)
        FMT_RJ16, FMT_RJ18: begin
          shreg_d = shifted;
          if (trans) begin
            capture = 1'b1;
            cap_val = (fmt == FMT_RJ16) ? {shreg_q[SHORT_W-1:0], {PAD_W{1'b0}}} : shreg_q;
          end
        end
        FMT_LJ18: begin
          if (trans) begin
            capture = 1'b1;
            cap_val = left_align(shreg_q, cnt_q);
            shreg_d = {{(SAMPLE_W-1){1'b0}}, sd_s};
            cnt_d   = CNT_W'(1);
          end else if (not_full) begin
            shreg_d = shifted;
            cnt_d   = cnt_q + 1'b1;
          end
        end
        FMT_I2S: begin
          if (trans) begin
            capture = 1'b1;
            cap_val = not_full ? left_align(shifted, cnt_q + 1'b1) : left_align(shreg_q, cnt_q);
            shreg_d = '0;
            cnt_d   = '0;
          end else if (not_full) begin
            shreg_d = shifted;
            cnt_d   = cnt_q + 1'b1;
          end
        end
      endcase
      if (capture && primed_q) begin
        valid_d = 1'b1;
        data_d  = cap_val;
        left_d  = (ws_prev_q == (fmt != FMT_I2S));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q   <= '0;
      cnt_q     <= '0;
      ws_prev_q <= 1'b0;
      seen_q    <= 1'b0;
      primed_q  <= 1'b0;
      valid_q   <= 1'b0;
      left_q    <= 1'b0;
      data_q    <= '0;
    end else begin
      shreg_q   <= shreg_d;
      cnt_q     <= cnt_d;
      ws_prev_q <= ws_prev_d;
      seen_q    <= seen_d;
      primed_q  <= primed_d;
      valid_q   <= valid_d;
      left_q    <= left_d;
      data_q    <= data_d;
    end
  end

  assign word_valid = valid_q;
  assign word_left  = left_q;
  assign word_data  = data_q;
endmodule

// File: rtl/aud_rx_pair.sv
module aud_rx_pair #(
  parameter int SAMPLE_W = 18
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                word_valid,
  input  logic                word_left,
  input  logic [SAMPLE_W-1:0] word_data,
  output logic                pair_stb,
  output logic [SAMPLE_W-1:0] left_w,
  output logic [SAMPLE_W-1:0] right_w
);
  logic [SAMPLE_W-1:0] hold_q, hold_d, l_q, l_d, r_q, r_d;
  logic have_q, have_d, stb_q, stb_d;

  always_comb begin
    hold_d = hold_q;
    have_d = have_q;
    l_d    = l_q;
    r_d    = r_q;
    stb_d  = 1'b0;
    if (word_valid) begin
      if (word_left) begin
        hold_d = word_data;
        have_d = 1'b1;
      end else if (have_q) begin
        stb_d  = 1'b1;
        l_d    = hold_q;
        r_d    = word_data;
        have_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      have_q <= 1'b0;
      l_q    <= '0;
      r_q    <= '0;
      stb_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      have_q <= have_d;
      l_q    <= l_d;
      r_q    <= r_d;
      stb_q  <= stb_d;
    end
  end

  assign pair_stb = stb_q;
  assign left_w   = l_q;
  assign right_w  = r_q;
endmodule

// File: rtl/aud_serial_rx.sv
module aud_serial_rx
  import aud_rx_pkg::*;
#(
  parameter int SAMPLE_W    = 18,
  parameter int SHORT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_clk_i,
  input  logic                frame_clk_i,
  input  logic                ser_dat_i,
  input  logic [1:0]          fmt_sel_i,
  output logic                pair_stb_o,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o
);
  localparam int LINES = 3;

  logic [LINES-1:0]    lines_s;
  logic                sclk_q, sclk_d, bit_rise;
  logic                word_valid, word_left;
  logic [SAMPLE_W-1:0] word_data;

  aud_rx_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ser_clk_i, frame_clk_i, ser_dat_i}),
    .dout (lines_s)
  );

  assign sclk_d   = lines_s[2];
  assign bit_rise = lines_s[2] & ~sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_d;
  end

  aud_rx_word #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_word (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_rise  (bit_rise),
    .ws_s      (lines_s[1]),
    .sd_s      (lines_s[0]),
    .fmt       (frame_fmt_e'(fmt_sel_i)),
    .word_valid(word_valid),
    .word_left (word_left),
    .word_data (word_data)
  );

  aud_rx_pair #(.SAMPLE_W(SAMPLE_W)) u_pair (
    .clk       (clk),
    .rst_n     (rst_n),
    .word_valid(word_valid),
    .word_left (word_left),
    .word_data (word_data),
    .pair_stb  (pair_stb_o),
    .left_w    (left_o),
    .right_w   (right_o)
  );
endmodule

// File: rtl/aud_serial_rx_chk.sv
module aud_serial_rx_chk #(
  parameter int SAMPLE_W = 18,
  parameter int SHORT_W  = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          fmt_sel_i,
  input logic                pair_stb_o,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                bit_rise
);
  localparam int PAD_W = SAMPLE_W - SHORT_W;

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_idle_r1: assert (!pair_stb_o && left_o == '0 && right_o == '0)
        else $error("R1 outputs not idle in reset");
    end
  end

  p_short_pad_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_stb_o && fmt_sel_i == 2'b00) |-> (left_o[PAD_W-1:0] == '0 && right_o[PAD_W-1:0] == '0));

  p_stb_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb_o |=> !pair_stb_o);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_stb_o |-> ($stable(left_o) && $stable(right_o)));

  p_stb_after_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pair_stb_o |-> $past(bit_rise, 2));
endmodule

bind aud_serial_rx aud_serial_rx_chk #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fmt_sel_i (fmt_sel_i),
  .pair_stb_o(pair_stb_o),
  .left_o    (left_o),
  .right_o   (right_o),
  .bit_rise  (bit_rise)
);

// File: tb/test_aud_serial_rx.sv
module test_aud_serial_rx;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n;
  logic ser_clk, frame_clk, ser_dat;
  logic [1:0] fmt_sel;
  logic pair_stb_o;
  logic [W-1:0] left_o, right_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;
  string cur_tag = "R1";
  int cur_fmt = 0;
  logic i2s_prev = 1'b0;
  logic [W-1:0] exp_l[$];
  logic [W-1:0] exp_r[$];
  logic [W-1:0] el, er;

  always #4 clk = ~clk;

  aud_serial_rx i_aud_serial_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_clk_i  (ser_clk),
    .frame_clk_i(frame_clk),
    .ser_dat_i  (ser_dat),
    .fmt_sel_i  (fmt_sel),
    .pair_stb_o (pair_stb_o),
    .left_o     (left_o),
    .right_o    (right_o)
  );

  // reference comparison on every clock: each strobe must match the next queued pair
  always @(negedge clk) begin
    if (rst_n === 1'b1 && pair_stb_o === 1'b1) begin
      if (exp_l.size() == 0) begin
        n_checks++; n_errors++;
        $display("FAIL R8 unexpected pair actual %h/%h expected none", left_o, right_o);
      end else begin
        el = exp_l.pop_front();
        er = exp_r.pop_front();
        n_checks++;
        if (left_o !== el) begin
          n_errors++;
          $display("FAIL %s left word (R6) actual %h expected %h", cur_tag, left_o, el);
        end
        n_checks++;
        if (right_o !== er) begin
          n_errors++;
          $display("FAIL %s right word (R6) actual %h expected %h", cur_tag, right_o, er);
        end
      end
    end
  end

  function automatic logic [W-1:0] pat(input int i, input int n);
    logic [15:0] p16;
    logic [W-1:0] p18;
    case (i % 5)
      0: begin p16 = 16'h8000; p18 = 18'h20000; end
      1: begin p16 = 16'h7FFF; p18 = 18'h1FFFF; end
      2: begin p16 = 16'h0001; p18 = 18'h00001; end
      3: begin p16 = 16'hA5C3; p18 = 18'h2B4C7; end
      default: begin p16 = 16'h0F0F; p18 = 18'h0F0F3; end
    endcase
    return (n == 16) ? {2'b00, p16} : p18;
  endfunction

  function automatic logic [W-1:0] expect_of(input logic [W-1:0] v, input int n);
    return (n == 16) ? {v[15:0], 2'b00} : v;
  endfunction

  task automatic tx_bit(input logic ws, input logic sd);
    @(negedge clk);
    ser_clk = 1'b0; frame_clk = ws; ser_dat = sd;
    repeat (3) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // unused slots carry ones so a wrong window corrupts the word
  task automatic tx_half(input logic ws, input logic [W-1:0] val, input int n, input int bpc);
    for (int k = 0; k < bpc; k++) begin
      logic b;
      if (cur_fmt < 2) b = (k < bpc - n) ? 1'b1 : val[n - 1 - (k - (bpc - n))];
      else             b = (k < n) ? val[n - 1 - k] : 1'b1;
      if (cur_fmt == 3) begin
        tx_bit(ws, i2s_prev);
        i2s_prev = b;
      end else begin
        tx_bit(ws, b);
      end
    end
  endtask

  task automatic run(input int fmt, input int n, input int bpc, input bit left_start,
                     input bit src16, input string tag);
    logic lv;
    logic [W-1:0] lval, rval;
    cur_fmt = fmt; cur_tag = tag;
    lv = (fmt != 3);
    rst_n = 1'b0; fmt_sel = 2'(fmt);
    ser_clk = 1'b0; ser_dat = 1'b0; i2s_prev = 1'b0;
    frame_clk = left_start ? lv : ~lv;
    repeat (4) @(negedge clk);
    n_checks++;
    if (pair_stb_o !== 1'b0 || left_o !== '0 || right_o !== '0) begin
      n_errors++;
      $display("FAIL R1 reset state actual %b/%h/%h expected 0/0/0", pair_stb_o, left_o, right_o);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    if (left_start) begin
      tx_half(lv, '1, n, bpc);
      tx_half(~lv, 18'h15555, n, bpc);   // R8: right word with no left before it
    end else begin
      tx_half(~lv, '1, n, bpc);
    end
    for (int f = 0; f < 4; f++) begin
      lval = pat(f, n);
      rval = pat(f + 2, n);
      if (src16) begin
        lval = {lval[W-1:2], 2'b00};
        rval = {rval[W-1:2], 2'b00};
      end
      exp_l.push_back(expect_of(lval, n));
      exp_r.push_back(expect_of(rval, n));
      tx_half(lv, lval, n, bpc);
      tx_half(~lv, rval, n, bpc);
    end
    tx_half(lv, '0, n, bpc);
    repeat (16) @(negedge clk);
    n_checks++;
    if (exp_l.size() != 0) begin
      n_errors++;
      $display("FAIL %s R7 pairs still pending actual %0d expected 0", tag, exp_l.size());
    end
    exp_l.delete();
    exp_r.delete();
  endtask

  initial begin
    rst_n = 1'b0;
    fmt_sel = 2'b00; ser_clk = 1'b0; frame_clk = 1'b0; ser_dat = 1'b0;
    run(0, 16, 16, 0, 0, "R2");   // 32 bit clocks per frame
    run(0, 16, 32, 0, 0, "R2");   // leading pad ignored
    run(1, 18, 18, 1, 0, "R3");   // also R8: stray right word dropped
    run(1, 18, 32, 0, 0, "R3");
    run(2, 18, 18, 0, 0, "R4");
    run(2, 18, 32, 0, 0, "R4");   // trailing pad ignored
    run(2, 18, 32, 0, 1, "R4");   // 16-bit source with zero LSBs
    run(3, 16, 16, 0, 0, "R5");   // 32 bit clocks per frame
    run(3, 18, 32, 0, 0, "R5");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL R7 watchdog expired actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule